// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

The block gathers eight interrupt sources of a bus message controller into a flag register. An enable register gates which flags may raise the shared active-low interrupt line. Hardware sets flags from one-cycle event pulses: an error, a bus wake-up, three transmit-buffer-empty events, two receive-complete events and a message error. The host can set or clear flags through a full write or a masked bit-modify. A flag stays set while its source condition still holds.

Alongside the interrupt line, the block reports a 3-bit code. The code names the highest-priority pending source among those that are enabled, and lower values mean higher priority. A bus-activity event sets the wake-up flag only while the device sleeps and wake-up is enabled. When that happens, the block raises a wake request.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, irq_no is 1 and icode_o is 000.
- R2: irq_no is 0 exactly when (flag_o & en_o) is nonzero. It follows any register change after one clock edge.
- R3: Bit positions in both registers are 0 error, 1 wake, 2 tx0, 3 tx1, 4 tx2, 5 rx0, 6 rx1 and 7 message error. icode_o is 1 + (lowest set bit index among bits 0..6 of flag & en), or 000 when none of those bits is set.
- R4: Flags whose enable bit is 0 never affect icode_o, and bit 7 (message error) never appears in icode_o, though it can still drive irq_no low.
- R5: A full write (wr_i) loads the register chosen by wr_sel_i (0 enable, 1 flag). Writing 1 to an enabled flag raises the interrupt as a hardware set would.
- R6: A bit-modify (bm_i) changes only the bits selected by bm_mask_i, loading them from bm_data_i. If wr_i is asserted in the same cycle, the bit-modify is ignored.
- R7: A host clear of a flag whose cond_i bit is 1 leaves that flag set.
- R8: A hardware event sets its flag even when a host clear hits the same bit in the same cycle. Events on bits outside a concurrent bit-modify mask are not lost.
- R9: The wake-up event (evt_i[1]) sets its flag only while sleep_i is 1 and enable bit 1 is 1. wake_req_o is 1 when sleep_i, flag bit 1 and enable bit 1 are all 1.
- R10: Hardware events on bits 0, 2..7 set their flags whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle hardware event pulses, one per source |
| cond_i | input | 8 | Source condition still active, per source |
| sleep_i | input | 1 | Device is in sleep mode |
| wr_i | input | 1 | Full register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 flag |
| wr_data_i | input | 8 | Full write data |
| bm_i | input | 1 | Bit-modify strobe |
| bm_sel_i | input | 1 | Bit-modify target: 0 enable, 1 flag |
| bm_mask_i | input | 8 | Bit-modify mask |
| bm_data_i | input | 8 | Bit-modify data |
| irq_no | output | 1 | Active-low interrupt |
| icode_o | output | 3 | Highest-priority pending enabled source code |
| en_o | output | 8 | Enable register readback |
| flag_o | output | 8 | Flag register readback |
| wake_req_o | output | 1 | Request to leave sleep |

## Verification
A flag that stays stuck, or one lost to a concurrent bit-modify, shows at flag_o one edge after the offending cycle. Through the enable gating, the same fault reaches irq_no and icode_o in that same cycle. A broken priority order shows as a wrong icode_o as soon as two enabled flags are pending together. The bench therefore checks the code while pending flags are cleared one at a time. A wrong wake-up gate shows as a flag bit 1 or a wake_req_o that appears while sleep_i is low, one edge after the bus event.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC   = 8;
  localparam int unsigned NUM_CODED = 7;
  localparam int unsigned CODE_W    = $clog2(NUM_CODED + 1);
  localparam int unsigned BIT_ERR   = 0;
  localparam int unsigned BIT_WAKE  = 1;
  localparam int unsigned BIT_MERR  = 7;
  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef enum logic {SEL_EN = 1'b0, SEL_FLAG = 1'b1} reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int unsigned W = NUM_SRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // set wins; held flags survive a host clear
    assign flag_d[i] = set_i[i] |
                       (mask_i[i] ? (data_i[i] | (flag_q[i] & cond_i[i])) : flag_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(set_i)) == $past(set_i))); // R8

  AST_HOLD_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(flag_q & cond_i)) == $past(flag_q & cond_i))); // R7

  AST_UNMASKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(mask_i | set_i)) == '0)); // R6
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int unsigned N  = NUM_CODED,
  parameter int unsigned CW = CODE_W
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o
);
  always_comb begin
    code_o = '0;
    // scan high to low so the lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic [NUM_SRC-1:0]  cond_i,
  input  logic                sleep_i,
  input  logic                wr_i,
  input  logic                wr_sel_i,
  input  logic [NUM_SRC-1:0]  wr_data_i,
  input  logic                bm_i,
  input  logic                bm_sel_i,
  input  logic [NUM_SRC-1:0]  bm_mask_i,
  input  logic [NUM_SRC-1:0]  bm_data_i,
  output logic                irq_no,
  output logic [CODE_W-1:0]   icode_o,
  output logic [NUM_SRC-1:0]  en_o,
  output logic [NUM_SRC-1:0]  flag_o,
  output logic                wake_req_o
);
  src_vec_t en_q, flag_q, hw_set, pend;
  src_vec_t en_mask, en_data, fl_mask, fl_data;

  // full write overrides bit-modify
  always_comb begin
    en_mask = '0; en_data = '0; fl_mask = '0; fl_data = '0;
    if (wr_i) begin
      if (reg_sel_e'(wr_sel_i) == SEL_FLAG) begin fl_mask = '1; fl_data = wr_data_i; end
      else                                  begin en_mask = '1; en_data = wr_data_i; end
    end else if (bm_i) begin
      if (reg_sel_e'(bm_sel_i) == SEL_FLAG) begin fl_mask = bm_mask_i; fl_data = bm_data_i; end
      else                                  begin en_mask = bm_mask_i; en_data = bm_data_i; end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q & ~en_mask) | (en_data & en_mask);
  end

  always_comb begin
    hw_set           = evt_i;
    hw_set[BIT_WAKE] = evt_i[BIT_WAKE] & sleep_i & en_q[BIT_WAKE];
  end

  irq_flag_bank #(.W(NUM_SRC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hw_set),
    .cond_i (cond_i),
    .mask_i (fl_mask),
    .data_i (fl_data),
    .flag_o (flag_q)
  );

  assign pend = flag_q & en_q;

  irq_prio_enc #(.N(NUM_CODED), .CW(CODE_W)) u_enc (
    .pend_i (pend[NUM_CODED-1:0]),
    .code_o (icode_o)
  );

  assign irq_no     = ~|pend;
  assign en_o       = en_q;
  assign flag_o     = flag_q;
  assign wake_req_o = sleep_i & pend[BIT_WAKE];

  AST_CODE_IMPLIES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icode_o != '0) |-> !irq_no); // R2

  AST_MERR_NOT_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & en_q) == src_vec_t'(1 << BIT_MERR)) |-> (icode_o == '0 && !irq_no)); // R4

  AST_WAKE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[BIT_WAKE]) |->
      $past(sleep_i && en_q[BIT_WAKE]) || $past(fl_mask[BIT_WAKE] && fl_data[BIT_WAKE])); // R9

  AST_WAKE_REQ_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> sleep_i && flag_q[BIT_WAKE]); // R9
endmodule

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] evt_i = '0, cond_i = '0, wr_data_i = '0, bm_mask_i = '0, bm_data_i = '0;
  logic sleep_i = 1'b0, wr_i = 1'b0, wr_sel_i = 1'b0, bm_i = 1'b0, bm_sel_i = 1'b0;
  logic irq_no, wake_req_o;
  logic [2:0] icode_o;
  logic [7:0] en_o, flag_o;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .cond_i(cond_i), .sleep_i(sleep_i),
    .wr_i(wr_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .bm_i(bm_i), .bm_sel_i(bm_sel_i), .bm_mask_i(bm_mask_i), .bm_data_i(bm_data_i),
    .irq_no(irq_no), .icode_o(icode_o), .en_o(en_o), .flag_o(flag_o), .wake_req_o(wake_req_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    wr_i = 1; wr_sel_i = sel; wr_data_i = d; step(); wr_i = 0;
  endtask

  task automatic bm(bit sel, logic [7:0] m, logic [7:0] d);
    bm_i = 1; bm_sel_i = sel; bm_mask_i = m; bm_data_i = d; step(); bm_i = 0;
  endtask

  task automatic pulse(logic [7:0] e);
    evt_i = e; step(); evt_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 en", en_o, 0); chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_no, 1); chk("R1 code", icode_o, 0);
  endtask

  task automatic t_hw_disabled();
    pulse(8'h28); // tx1, rx0
    chk("R10 flag set disabled", flag_o, 8'h28);
    chk("R4 code disabled", icode_o, 0);
    chk("R2 irq disabled", irq_no, 1);
    wr(1'b0, 8'h20);
    chk("R3 rx0 code", icode_o, 6); chk("R2 irq low", irq_no, 0);
  endtask

  task automatic t_priority();
    wr(1'b0, 8'hFF);
    chk("R3 tx1 top", icode_o, 4);
    pulse(8'h01);
    chk("R3 err top", icode_o, 1);
    bm(1'b1, 8'h01, 8'h00);
    chk("R3 after err clear", icode_o, 4);
    bm(1'b1, 8'h08, 8'h00);
    chk("R3 after tx1 clear", icode_o, 6);
    bm(1'b1, 8'h20, 8'h00);
    chk("R2 all cleared", irq_no, 1); chk("R3 none", icode_o, 0);
  endtask

  task automatic t_merr();
    pulse(8'h80);
    chk("R4 merr irq", irq_no, 0); chk("R4 merr code", icode_o, 0);
    pulse(8'h40);
    chk("R3 rx1 code", icode_o, 7);
    wr(1'b1, 8'h00);
    chk("R5 write clears", flag_o, 0);
  endtask

  task automatic t_sw_set();
    wr(1'b1, 8'h10);
    chk("R5 sw set flag", flag_o, 8'h10);
    chk("R5 sw set code", icode_o, 5); chk("R5 sw set irq", irq_no, 0);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_cond_hold();
    wr(1'b1, 8'h04); cond_i = 8'h04;
    bm(1'b1, 8'h04, 8'h00);
    chk("R7 held flag", flag_o, 8'h04);
    cond_i = 8'h00;
    bm(1'b1, 8'h04, 8'h00);
    chk("R7 released clear", flag_o, 0);
  endtask

  task automatic t_collide();
    wr(1'b1, 8'h06);
    evt_i = 8'h21; bm_i = 1; bm_sel_i = 1; bm_mask_i = 8'h07; bm_data_i = 8'h00;
    step(); evt_i = 0; bm_i = 0;
    chk("R8 set wins and unmasked kept", flag_o, 8'h21);
    bm(1'b0, 8'hF0, 8'h00);
    chk("R6 bm enable masked only", en_o, 8'h0F);
    wr_i = 1; wr_sel_i = 0; wr_data_i = 8'hFF; bm_i = 1; bm_sel_i = 0; bm_mask_i = 8'hFF; bm_data_i = 8'h00;
    step(); wr_i = 0; bm_i = 0;
    chk("R6 write over bm", en_o, 8'hFF);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_wake();
    sleep_i = 0; pulse(8'h02);
    chk("R9 awake ignores bus", flag_o, 0);
    sleep_i = 1; wr(1'b0, 8'hFD); pulse(8'h02);
    chk("R9 wake disabled ignored", flag_o, 0);
    wr(1'b0, 8'hFF); pulse(8'h02);
    chk("R9 wake flag", flag_o, 8'h02);
    chk("R9 wake req", wake_req_o, 1); chk("R3 wake code", icode_o, 2);
    sleep_i = 0; step();
    chk("R9 req drops awake", wake_req_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1; @(negedge clk);
    t_reset(); t_hw_disabled(); t_priority(); t_merr(); t_sw_set();
    t_cond_hold(); t_collide(); t_wake();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); chk("watchdog", 0, 1); end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule